// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold Interrupts

This block sits between a register interface and a serial bus engine. It holds two byte FIFOs: a transmit queue that the host fills and the engine drains, and a receive queue that the engine fills and the host drains. Each queue has an enable bit and a programmable threshold. A transmit queue that runs low and a receive queue that fills up both raise interrupt conditions. So does a push into a full queue or a pop from an empty one.

A trailing timer covers the tail of a receive stream that never reaches the receive threshold. Once the receive queue holds some bytes, stays below its threshold, and sees a programmed number of idle engine ticks with no new byte, an interrupt condition is raised. The host can then drain the leftover bytes. All conditions land in sticky status bits that are cleared by writing ones. Three of them can drive the single interrupt line through an enable mask.

Top module: `fifo_irq_unit`

## Requirements
- R1: In `fifo_ctl`, bit 0 enables the receive queue and bit 1 enables the transmit queue. While its enable is 0 a queue is emptied at every clock edge. Its pushes and pops have no effect, and it raises none of its status conditions.
- R2: Each enabled queue keeps DEPTH (default 16) bytes in first-in first-out order. The oldest byte is always presented on `eng_tx_data` (transmit) or `host_rx_data` (receive) while the queue is non-empty. A pop and a push in the same cycle are both honoured when the queue is neither empty nor full.
- R3: `fifo_status` holds the following fields. All other bits are 0.
  - Transmit level in bits 6:0, transmit full at bit 7, transmit empty at bit 8.
  - Receive level in bits 22:16, receive full at bit 23, receive empty at bit 24.
- R4: A push into a full queue drops its byte, even if a pop occurs in the same cycle. It sets status bit 3 for transmit or bit 5 for receive.
- R5: A pop from an empty queue returns nothing and leaves the queue unchanged. It sets status bit 2 for transmit or bit 4 for receive.
- R6: The two threshold fields are 7 bits wide.
  - Status bit 0 is set while the enabled transmit level is at or below the threshold in `fifo_ctl[22:16]`.
  - Status bit 1 is set while the enabled receive level is at or above the threshold in `fifo_ctl[10:4]`.
  - Every status bit is set at the clock edge that follows the cycle in which its condition or event is seen.
- R7: Status bits are sticky. A write with `stat_wr` clears each bit whose `stat_wdata` bit is 1. A condition present in the same cycle as the clear wins. Writing back the value just read clears everything pending.
- R8: The trailing timer counts `eng_tick` cycles under these conditions: the receive queue is enabled and non-empty, it is below the receive threshold, and there is no receive push. If any of these conditions fails, the counter restarts. When the tick that makes the count equal `trail_len` arrives, status bit 6 is set, once per idle stretch.
- R9: A `trail_len` of 0 never sets status bit 6.
- R10: `irq` is 1 exactly when a status bit at position 0, 1 or 6 is set and the bit with the same index of `int_en` is 1. Status bits 2 to 5 never drive `irq`.
- R11: After reset, all status bits are 0, both levels are 0, `fifo_status` reads 0x01000100, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_ctl | input | 32 | Queue enables and threshold fields |
| int_en | input | 32 | Interrupt enables (bits 0, 1, 6 used) |
| trail_len | input | 4 | Idle tick count for the trailing timer |
| stat_wr | input | 1 | Status clear strobe |
| stat_wdata | input | 32 | Write-one-to-clear mask for status |
| host_tx_push | input | 1 | Host pushes a transmit byte |
| host_tx_data | input | 8 | Transmit byte from host |
| host_rx_pop | input | 1 | Host pops a receive byte |
| host_rx_data | output | 8 | Oldest receive byte |
| eng_tx_pop | input | 1 | Engine pops a transmit byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_rx_push | input | 1 | Engine pushes a receive byte |
| eng_rx_data | input | 8 | Receive byte from engine |
| eng_tick | input | 1 | Idle bus-clock tick from engine |
| int_status | output | 32 | Sticky status bits 6:0 |
| fifo_status | output | 32 | Levels and full/empty flags |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check on every cycle the following properties:
- A queue stays within its depth and is never both full and empty.
- A dropped push leaves a full queue full, and a failed pop leaves an empty queue empty.
- A disabled queue is empty one edge later.
- Status bits hold until cleared, and a condition present in the same cycle as a clear wins.
- The trailing event fires only below the threshold, at most once per idle stretch, and never with a zero count.
- `irq` stays low unless an enabled, interrupt-capable bit is set.

Only the bench's scenarios can show byte ordering through the queues, the exact cycle on which each threshold and trailing bit appears, the status word layout, and that writing back a read value empties the status. The bench shows these by replaying random and directed traffic against its own queue model.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

  localparam int CTL_RX_EN       = 0;
  localparam int CTL_TX_EN       = 1;
  localparam int CTL_RX_TRIG_LSB = 4;
  localparam int CTL_TX_TRIG_LSB = 16;
  localparam int TRIG_W          = 7;
  localparam int LVL_W           = 7;
  localparam int TRAIL_W         = 4;

  localparam int ST_TX_LOW   = 0;
  localparam int ST_RX_HIGH  = 1;
  localparam int ST_TX_UNDER = 2;
  localparam int ST_TX_OVER  = 3;
  localparam int ST_RX_UNDER = 4;
  localparam int ST_RX_OVER  = 5;
  localparam int ST_TRAIL    = 6;
  localparam int NSTAT       = 7;

  localparam logic [NSTAT-1:0] IRQ_CAPABLE = 7'b100_0011;

  typedef struct packed {
    logic [LVL_W-1:0] level;
    logic             full;
    logic             empty;
  } fifo_view_t;

  function automatic logic [TRIG_W-1:0] get_trig(input logic [31:0] w, input int lsb);
    return w[lsb +: TRIG_W];
  endfunction

  function automatic logic [31:0] pack_fifo_word(input fifo_view_t tx, input fifo_view_t rx);
    logic [31:0] w;
    w        = '0;
    w[6:0]   = tx.level;
    w[7]     = tx.full;
    w[8]     = tx.empty;
    w[22:16] = rx.level;
    w[23]    = rx.full;
    w[24]    = rx.empty;
    return w;
  endfunction

  function automatic logic lvl_le(input logic [LVL_W-1:0] lvl, input logic [TRIG_W-1:0] trig);
    return lvl <= trig;
  endfunction

  function automatic logic lvl_ge(input logic [LVL_W-1:0] lvl, input logic [TRIG_W-1:0] trig);
    return lvl >= trig;
  endfunction

  function automatic logic trail_reached(input logic [TRAIL_W-1:0] cnt,
                                         input logic [TRAIL_W-1:0] lim);
    return (lim != '0) && (({1'b0, cnt} + 1'b1) == {1'b0, lim});
  endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          ovf_ev,
  output logic          unf_ev
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          acc_push, acc_pop;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (cnt == LW'(DEPTH));
  assign empty    = (cnt == '0);
  assign level    = cnt;
  assign rdata    = mem[rp];
  assign acc_push = en && push && !full;
  assign acc_pop  = en && pop && !empty;
  assign ovf_ev   = en && push && full;
  assign unf_ev   = en && pop && empty;

  always_ff @(posedge clk) begin
    if (acc_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (!en) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (acc_push) wp <= next_ptr(wp);
      if (acc_pop)  rp <= next_ptr(rp);
      cnt <= cnt + LW'(acc_push) - LW'(acc_pop);
    end
  end

  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LW'(DEPTH));
  a_r2_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  a_r4_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ev && !pop) |=> full);
  a_r5_empty_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_ev && !push) |=> empty);
  a_r1_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (level == '0));

endmodule

// File: rtl/trail_timer.sv
module trail_timer
  import fifo_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               qualify,
  input  logic               tick,
  input  logic [TRAIL_W-1:0] limit,
  output logic               fire
);
  logic [TRAIL_W-1:0] cnt;

  assign fire = qualify && tick && trail_reached(cnt, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!qualify)          cnt <= '0;
    else if (tick && cnt < limit) cnt <= cnt + 1'b1;
  end

  a_r9_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0) |-> !fire);
  a_r8_fire_once: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (!fire || (limit != $past(limit))));

endmodule

// File: rtl/irq_status.sv
module irq_status
  import fifo_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTAT-1:0] set_ev,
  input  logic             clr_we,
  input  logic [NSTAT-1:0] clr_mask,
  input  logic [NSTAT-1:0] en_mask,
  output logic [NSTAT-1:0] stat,
  output logic             irq
);
  logic [NSTAT-1:0] stat_q, stat_d;

  for (genvar i = 0; i < NSTAT; i++) begin : g_bit
    assign stat_d[i] = (stat_q[i] && !(clr_we && clr_mask[i])) || set_ev[i];

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[i] && !(clr_we && clr_mask[i])) |=> stat_q[i]);
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> stat_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat = stat_q;
  assign irq  = |(stat_q & en_mask & IRQ_CAPABLE);

  a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & IRQ_CAPABLE) == '0) |-> !irq);
  a_r10_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_mask & IRQ_CAPABLE) == '0) |-> !irq);

endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        fifo_ctl,
  input  logic [31:0]        int_en,
  input  logic [TRAIL_W-1:0] trail_len,
  input  logic               stat_wr,
  input  logic [31:0]        stat_wdata,
  input  logic               host_tx_push,
  input  logic [DW-1:0]      host_tx_data,
  input  logic               host_rx_pop,
  output logic [DW-1:0]      host_rx_data,
  input  logic               eng_tx_pop,
  output logic [DW-1:0]      eng_tx_data,
  input  logic               eng_rx_push,
  input  logic [DW-1:0]      eng_rx_data,
  input  logic               eng_tick,
  output logic [31:0]        int_status,
  output logic [31:0]        fifo_status,
  output logic               irq
);
  localparam int LW = $clog2(DEPTH + 1);

  logic              tx_en, rx_en;
  logic [TRIG_W-1:0] tx_trig, rx_trig;
  logic [LW-1:0]     tx_lvl_raw, rx_lvl_raw;
  logic [LVL_W-1:0]  tx_lvl, rx_lvl;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_ovf, tx_unf, rx_ovf, rx_unf;
  logic              trail_qual, trail_fire;
  logic [NSTAT-1:0]  set_ev, stat;
  fifo_view_t        tx_view, rx_view;

  assign tx_en   = fifo_ctl[CTL_TX_EN];
  assign rx_en   = fifo_ctl[CTL_RX_EN];
  assign tx_trig = get_trig(fifo_ctl, CTL_TX_TRIG_LSB);
  assign rx_trig = get_trig(fifo_ctl, CTL_RX_TRIG_LSB);

  byte_fifo #(.DEPTH(DEPTH), .DW(DW), .LW(LW)) u_tx_fifo (
    .clk, .rst_n, .en(tx_en),
    .push(host_tx_push), .wdata(host_tx_data),
    .pop(eng_tx_pop), .rdata(eng_tx_data),
    .level(tx_lvl_raw), .full(tx_full), .empty(tx_empty),
    .ovf_ev(tx_ovf), .unf_ev(tx_unf)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(DW), .LW(LW)) u_rx_fifo (
    .clk, .rst_n, .en(rx_en),
    .push(eng_rx_push), .wdata(eng_rx_data),
    .pop(host_rx_pop), .rdata(host_rx_data),
    .level(rx_lvl_raw), .full(rx_full), .empty(rx_empty),
    .ovf_ev(rx_ovf), .unf_ev(rx_unf)
  );

  assign tx_lvl = LVL_W'(tx_lvl_raw);
  assign rx_lvl = LVL_W'(rx_lvl_raw);

  assign trail_qual = rx_en && !rx_empty && !lvl_ge(rx_lvl, rx_trig) && !eng_rx_push;

  trail_timer u_trail (
    .clk, .rst_n,
    .qualify(trail_qual), .tick(eng_tick), .limit(trail_len),
    .fire(trail_fire)
  );

  always_comb begin
    set_ev              = '0;
    set_ev[ST_TX_LOW]   = tx_en && lvl_le(tx_lvl, tx_trig);
    set_ev[ST_RX_HIGH]  = rx_en && lvl_ge(rx_lvl, rx_trig);
    set_ev[ST_TX_UNDER] = tx_unf;
    set_ev[ST_TX_OVER]  = tx_ovf;
    set_ev[ST_RX_UNDER] = rx_unf;
    set_ev[ST_RX_OVER]  = rx_ovf;
    set_ev[ST_TRAIL]    = trail_fire;
  end

  irq_status u_stat (
    .clk, .rst_n,
    .set_ev(set_ev), .clr_we(stat_wr), .clr_mask(stat_wdata[NSTAT-1:0]),
    .en_mask(int_en[NSTAT-1:0]),
    .stat(stat), .irq(irq)
  );

  assign tx_view     = '{level: tx_lvl, full: tx_full, empty: tx_empty};
  assign rx_view     = '{level: rx_lvl, full: rx_full, empty: rx_empty};
  assign fifo_status = pack_fifo_word(tx_view, rx_view);
  assign int_status  = {{(32-NSTAT){1'b0}}, stat};

  a_r8_trail_below: assert property (@(posedge clk) disable iff (!rst_n)
    trail_fire |-> (!rx_empty && (rx_lvl < rx_trig)));
  a_r1_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !(tx_ovf || tx_unf));

endmodule

// File: tb/fifo_irq_unit_tb_top.sv
module fifo_irq_unit_tb_top;
  localparam int D = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctl = '0, ien = '0, swd = '0;
  logic [3:0]  tlen = '0;
  logic        swr = 0, txp = 0, rxpop = 0, txpop = 0, rxp = 0, tick = 0;
  logic [7:0]  txd = '0, rxd = '0;
  logic [7:0]  host_rx_data, eng_tx_data;
  logic [31:0] int_status, fifo_status;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  logic [6:0] stat_m = '0;
  int         tcnt = 0;

  always #10 clk = ~clk;

  fifo_irq_unit dut_i (
    .clk, .rst_n, .fifo_ctl(ctl), .int_en(ien), .trail_len(tlen),
    .stat_wr(swr), .stat_wdata(swd),
    .host_tx_push(txp), .host_tx_data(txd), .host_rx_pop(rxpop),
    .host_rx_data(host_rx_data), .eng_tx_pop(txpop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(rxp), .eng_rx_data(rxd), .eng_tick(tick),
    .int_status(int_status), .fifo_status(fifo_status), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string bit_req(input int i);
    case (i)
      0, 1:    return "R6";
      2, 4:    return "R5";
      3, 5:    return "R4";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [31:0] exp_fifo_word();
    logic [31:0] w = '0;
    w[6:0]   = 7'(tx_q.size());
    w[7]     = (tx_q.size() == D);
    w[8]     = (tx_q.size() == 0);
    w[22:16] = 7'(rx_q.size());
    w[23]    = (rx_q.size() == D);
    w[24]    = (rx_q.size() == 0);
    return w;
  endfunction

  function automatic logic exp_irq();
    return |(stat_m & ien[6:0] & 7'b100_0011);
  endfunction

  task automatic compare();
    for (int i = 0; i < 7; i++)
      chk(int_status[i] === stat_m[i], bit_req(i), 32'(int_status[i]), 32'(stat_m[i]));
    chk(int_status[31:7] === '0, "R7", int_status, {25'b0, stat_m});
    chk(fifo_status === exp_fifo_word(), "R3", fifo_status, exp_fifo_word());
    chk(irq === exp_irq(), "R10", 32'(irq), 32'(exp_irq()));
    if (tx_q.size() > 0) chk(eng_tx_data === tx_q[0], "R2", 32'(eng_tx_data), 32'(tx_q[0]));
    if (rx_q.size() > 0) chk(host_rx_data === rx_q[0], "R2", 32'(host_rx_data), 32'(rx_q[0]));
  endtask

  // Applies the inputs currently driven for one clock, advances the model, compares.
  task automatic cycle();
    logic       tx_en = ctl[1], rx_en = ctl[0];
    int         rxt = int'(ctl[10:4]), txt = int'(ctl[22:16]);
    int         txl = tx_q.size(), rxl = rx_q.size();
    logic [6:0] set = '0;
    bit         qual;
    if (tx_en) begin
      set[0] = (txl <= txt);
      set[3] = txp && (txl == D);
      set[2] = txpop && (txl == 0);
    end
    if (rx_en) begin
      set[1] = (rxl >= rxt);
      set[5] = rxp && (rxl == D);
      set[4] = rxpop && (rxl == 0);
    end
    qual = rx_en && (rxl > 0) && (rxl < rxt) && !rxp;
    if (qual && tick && tlen != 0 && tcnt + 1 == int'(tlen)) set[6] = 1'b1;
    if (!qual) tcnt = 0;
    else if (tick && tcnt < int'(tlen)) tcnt++;
    stat_m = (stat_m & ~(swr ? swd[6:0] : 7'b0)) | set;
    if (!tx_en) tx_q.delete();
    else begin
      if (txpop && txl > 0) void'(tx_q.pop_front());
      if (txp && txl < D) tx_q.push_back(txd);
    end
    if (!rx_en) rx_q.delete();
    else begin
      if (rxpop && rxl > 0) void'(rx_q.pop_front());
      if (rxp && rxl < D) rx_q.push_back(rxd);
    end
    @(posedge clk);
    @(negedge clk);
    compare();
    swr = 0; txp = 0; rxpop = 0; txpop = 0; rxp = 0; tick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk(int_status === 32'h0, "R11", int_status, 32'h0);
    chk(fifo_status === 32'h0100_0100, "R11", fifo_status, 32'h0100_0100);
    chk(irq === 1'b0, "R11", 32'(irq), 0);

    // R1: disabled queues ignore traffic
    ctl = 32'h0; txp = 1; txd = 8'h11; rxp = 1; rxd = 8'h22; txpop = 1; rxpop = 1;
    cycle();
    chk(fifo_status === 32'h0100_0100 && int_status === 32'h0, "R1",
        fifo_status, 32'h0100_0100);

    // R4/R6: fill TX past full with threshold 4
    ctl = (32'd4 << 16) | 32'h2;
    for (int i = 0; i < D + 1; i++) begin
      txp = 1; txd = 8'(8'hA0 + i);
      cycle();
    end
    chk(int_status[3] === 1'b1, "R4", int_status, 32'h8);
    chk(fifo_status[7] === 1'b1, "R4", fifo_status, exp_fifo_word());
    chk(int_status[0] === 1'b1, "R6", int_status, 32'h1);
    for (int i = 0; i < 3; i++) begin
      txpop = 1;
      cycle();
    end

    // R5: pop empty RX
    ctl = 32'h1 | (32'd2 << 4);
    rxpop = 1;
    cycle();
    chk(int_status[4] === 1'b1, "R5", int_status, 32'h10);

    // R7: write back value read clears all (no conditions active)
    ctl = 32'h0;
    cycle();
    swr = 1; swd = int_status;
    cycle();
    chk(int_status === 32'h0, "R7", int_status, 32'h0);
    ctl = (32'd4 << 16) | 32'h2;
    cycle();
    swr = 1; swd = 32'h1;
    cycle();
    chk(int_status[0] === 1'b1, "R7", int_status, 32'h1);

    // R9 then R8: trailing timer
    ctl = 32'h1 | (32'd8 << 4); tlen = 4'd0;
    swr = 1; swd = 32'h7F;
    cycle();
    rxp = 1; rxd = 8'h5C;
    cycle();
    for (int i = 0; i < 20; i++) begin
      tick = 1;
      cycle();
    end
    chk(int_status[6] === 1'b0, "R9", int_status, 32'h0);
    tlen = 4'd3;
    tick = 1; cycle();
    tick = 1; cycle();
    chk(int_status[6] === 1'b0, "R8", int_status, 32'h0);
    tick = 1; cycle();
    chk(int_status[6] === 1'b1, "R8", int_status, 32'h40);

    // R10: non-capable bits never raise irq
    ctl = 32'h2; swr = 1; swd = 32'h7F;
    cycle();
    ien = 32'h0000_003C; txpop = 1;
    cycle();
    chk(int_status[2] === 1'b1 && irq === 1'b0, "R10", 32'(irq), 0);
    ien = 32'h1;
    cycle();
    chk(irq === 1'b1, "R10", 32'(irq), 1);

    // Random traffic
    for (int n = 0; n < 5000; n++) begin
      if (n % 250 == 0) begin
        ctl = '0;
        ctl[0] = ($urandom_range(0, 9) != 0);
        ctl[1] = ($urandom_range(0, 9) != 0);
        ctl[10:4]  = 7'($urandom_range(0, 18));
        ctl[22:16] = 7'($urandom_range(0, 18));
        ien  = $urandom;
        tlen = 4'($urandom_range(0, 15));
      end
      txp = ($urandom_range(0, 99) < 50); txd = 8'($urandom);
      txpop = ($urandom_range(0, 99) < 40);
      rxp = ($urandom_range(0, 99) < 25); rxd = 8'($urandom);
      rxpop = ($urandom_range(0, 99) < 30);
      tick = ($urandom_range(0, 99) < 60);
      swr = ($urandom_range(0, 99) < 10); swd = $urandom;
      cycle();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule